// File: doc/BRIEF.md
# Burst-Fed Pairwise Averaging Engine

This block is a memory-bus master. It turns an input array of 32-bit unsigned words into an output array. Each output word is the mean of two adjacent input words, rounded down. The sum of the two words wraps at 32 bits before it is halved. Software gives it two byte base addresses and a start pulse. The engine then works through the arrays in groups of four outputs and pulses done once the last group has been written.

Each group passes through a fixed sequence of phases:
- A single read burst of five consecutive input words. The fifth word is the right-hand neighbour that the fourth output needs, and each word is fetched exactly once.
- One execute cycle in which four averaging lanes work in parallel.
- A single write burst that places the four results at consecutive output addresses.

Each of the read request, read data, write request and write data channels uses a valid/ready handshake. Burst lengths are encoded as the beat count minus one.

Top module: `pavg_accel`

## Requirements
- R1: Output word i equals ((in[i] + in[i+1]) mod 2^32) >> 1, with both operands treated as unsigned 32-bit words.
- R2: Group g issues exactly one read request, with rd_addr = in_base + 16*g and rd_len = 4 (five beats). The five returned beats hold input words 4g through 4g+4 in that order, and no word is requested twice within the group.
- R3: The read request of a group is accepted and all five of its read beats are consumed before the write request of that group is issued. The write request has wr_addr = out_base + 16*g and wr_len = 3. Four data beats follow, in output order, and wr_last is high on the fourth beat only.
- R4: Groups are processed in ascending order from g = 0 to g = N_GROUPS-1, which is 255 by default. No request is issued for any other group, so input indices stay in 0..1024 and output indices stay in 0..1023.
- R5: While rd_req_valid is high and rd_req_ready is low, rd_req_valid stays high and rd_addr and rd_len stay unchanged.
- R6: While wr_valid is high and wr_ready is low, wr_valid stays high and wr_data and wr_last stay unchanged. While wr_req_valid is high and wr_req_ready is low, wr_addr stays unchanged.
- R7: done is high for exactly one cycle, in the cycle after the last write beat of group N_GROUPS-1 is accepted. The engine then returns to idle and a later start begins a new pass.
- R8: in_base and out_base are captured when start is accepted in idle. A start, and any change of the base inputs, while a pass is running has no effect on the addresses.
- R9: While rst_n is low and after it is released, no valid output and no done is asserted until a new start arrives, even if the reset interrupted a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (sampled only while idle) |
| in_base | input | 32 | Byte base address of the input array |
| out_base | input | 32 | Byte base address of the output array |
| done | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Read burst request valid |
| rd_req_ready | input | 1 | Read burst request accepted |
| rd_addr | output | 32 | Read burst start byte address |
| rd_len | output | 4 | Read burst beats minus one |
| rd_data_valid | input | 1 | Read data beat valid |
| rd_data_ready | output | 1 | Engine accepts read data |
| rd_data | input | 32 | Read data beat |
| wr_req_valid | output | 1 | Write burst request valid |
| wr_req_ready | input | 1 | Write burst request accepted |
| wr_addr | output | 32 | Write burst start byte address |
| wr_len | output | 4 | Write burst beats minus one |
| wr_valid | output | 1 | Write data beat valid |
| wr_ready | input | 1 | Write data beat accepted |
| wr_data | output | 32 | Write data beat |
| wr_last | output | 1 | Final beat of the write burst |

## Verification
A corrupted group counter or base register appears at the very next request handshake as a wrong rd_addr or wr_addr. It therefore shows within one group, about a dozen cycles. A misplaced read beat, or a lane with a wrong carry, shows on the first write data beat that uses that word. The bench compares every accepted beat against values it computes itself, with random stalls on all four channels. A phase counter that slips shows as a misplaced wr_last, as a write request arriving before its five read beats, or as done appearing in a cycle other than the one right after the final beat.

// File: rtl/pavg_pkg.sv
package pavg_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RREQ,
    S_RDAT,
    S_EXEC,
    S_WREQ,
    S_WDAT,
    S_FIN
  } phase_e;
endpackage

// File: rtl/pavg_ctrl.sv
module pavg_ctrl
  import pavg_pkg::*;
#(
  parameter int N_GROUPS = 256,
  parameter int LANES    = 4,
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 4,
  parameter int BEAT_W   = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] out_base,
  input  logic              rd_req_ready,
  input  logic              rd_data_valid,
  input  logic              wr_req_ready,
  input  logic              wr_ready,
  output logic [BEAT_W-1:0] beat,
  output logic              win_we,
  output logic              exec_en,
  output logic              rd_req_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic              rd_data_ready,
  output logic              wr_req_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_len,
  output logic              wr_valid,
  output logic              wr_last,
  output logic              done
);
  localparam int GRP_W  = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
  localparam int STRIDE = LANES * 4;

  phase_e            st_q, st_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [ADDR_W-1:0] ib_q, ob_q;
  logic              base_en;
  logic [ADDR_W-1:0] grp_off;

  assign base_en = (st_q == S_IDLE) && start;

  always_comb begin
    st_d   = st_q;
    grp_d  = grp_q;
    beat_d = beat_q;
    case (st_q)
      S_IDLE: if (start) begin
        st_d  = S_RREQ;
        grp_d = '0;
      end
      S_RREQ: if (rd_req_ready) begin
        st_d   = S_RDAT;
        beat_d = '0;
      end
      S_RDAT: if (rd_data_valid) begin
        if (beat_q == BEAT_W'(LANES)) st_d = S_EXEC;
        else beat_d = beat_q + BEAT_W'(1);
      end
      S_EXEC: st_d = S_WREQ;
      S_WREQ: if (wr_req_ready) begin
        st_d   = S_WDAT;
        beat_d = '0;
      end
      S_WDAT: if (wr_ready) begin
        if (beat_q == BEAT_W'(LANES - 1)) begin
          if (grp_q == GRP_W'(N_GROUPS - 1)) st_d = S_FIN;
          else begin
            st_d  = S_RREQ;
            grp_d = grp_q + GRP_W'(1);
          end
        end else begin
          beat_d = beat_q + BEAT_W'(1);
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      grp_q  <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      grp_q  <= grp_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ib_q <= '0;
      ob_q <= '0;
    end else if (base_en) begin
      ib_q <= in_base;
      ob_q <= out_base;
    end
  end

  assign grp_off       = ADDR_W'(grp_q) * ADDR_W'(STRIDE);
  assign beat          = beat_q;
  assign rd_req_valid  = (st_q == S_RREQ);
  assign rd_addr       = ib_q + grp_off;
  assign rd_len        = LEN_W'(LANES);
  assign rd_data_ready = (st_q == S_RDAT);
  assign win_we        = rd_data_ready && rd_data_valid;
  assign exec_en       = (st_q == S_EXEC);
  assign wr_req_valid  = (st_q == S_WREQ);
  assign wr_addr       = ob_q + grp_off;
  assign wr_len        = LEN_W'(LANES - 1);
  assign wr_valid      = (st_q == S_WDAT);
  assign wr_last       = wr_valid && (beat_q == BEAT_W'(LANES - 1));
  assign done          = (st_q == S_FIN);

  // R5: a stalled read request keeps its contents
  p_rreq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr) && $stable(rd_len));
  // R6: a stalled write request and a stalled write beat keep their contents
  p_wreq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid && !wr_req_ready |=> wr_req_valid && $stable(wr_addr));
  p_wlast_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_last));
  // R3: the fifth accepted read beat leads straight into execute
  p_load_then_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_we && (beat == BEAT_W'(LANES)) |=> exec_en);
  // R7: done lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: bases are frozen while busy
  p_base_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |=> $stable(ib_q) && $stable(ob_q));
endmodule

// File: rtl/pavg_window.sv
module pavg_window #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 5,
  parameter int BEAT_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BEAT_W-1:0] beat,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word [WORDS]
);
  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic hit;
    assign hit = we && (beat == BEAT_W'(i));
    always_ff @(posedge clk) begin
      if (hit) word_q[i] <= wdata;
    end
    assign word[i] = word_q[i];
  end

  // R2: the beat counter never runs past the five-word window
  p_beat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (beat <= BEAT_W'(WORDS - 1)));
endmodule

// File: rtl/pavg_lanes.sv
module pavg_lanes #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              en,
  input  logic [DATA_W-1:0] win [LANES+1],
  output logic [DATA_W-1:0] res [LANES]
);
  logic [DATA_W-1:0] res_q [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DATA_W-1:0] sum;
    assign sum = win[i] + win[i+1];
    always_ff @(posedge clk) begin
      if (en) res_q[i] <= sum >> 1;
    end
    assign res[i] = res_q[i];
  end
endmodule

// File: rtl/pavg_accel.sv
module pavg_accel #(
  parameter int N_GROUPS = 256,
  parameter int LANES    = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] out_base,
  output logic              done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  input  logic              rd_data_valid,
  output logic              rd_data_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req_valid,
  input  logic              wr_req_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_len,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_last
);
  localparam int WORDS  = LANES + 1;
  localparam int BEAT_W = $clog2(WORDS);
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [BEAT_W-1:0] beat;
  logic              win_we;
  logic              exec_en;
  logic [DATA_W-1:0] win [WORDS];
  logic [DATA_W-1:0] res [LANES];

  pavg_ctrl #(
    .N_GROUPS(N_GROUPS), .LANES(LANES), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .BEAT_W(BEAT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_base(in_base), .out_base(out_base),
    .rd_req_ready(rd_req_ready), .rd_data_valid(rd_data_valid),
    .wr_req_ready(wr_req_ready), .wr_ready(wr_ready),
    .beat(beat), .win_we(win_we), .exec_en(exec_en),
    .rd_req_valid(rd_req_valid), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_data_ready(rd_data_ready),
    .wr_req_valid(wr_req_valid), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_valid(wr_valid), .wr_last(wr_last), .done(done)
  );

  pavg_window #(.DATA_W(DATA_W), .WORDS(WORDS), .BEAT_W(BEAT_W)) u_window (
    .clk(clk), .rst_n(rst_n), .we(win_we), .beat(beat),
    .wdata(rd_data), .word(win)
  );

  pavg_lanes #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
    .clk(clk), .en(exec_en), .win(win), .res(res)
  );

  assign wr_data = res[beat[LIDX_W-1:0]];

  // R6: a stalled write beat keeps its data
  p_wdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_data));
endmodule

// File: tb/pavg_accel_bench.sv
`timescale 1ns/1ps
module pavg_accel_bench;
  localparam int NG = 256;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [31:0] in_base, out_base;
  logic        done, rd_req_valid, rd_req_ready, rd_data_valid, rd_data_ready;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [3:0]  rd_len, wr_len;
  logic        wr_req_valid, wr_req_ready, wr_valid, wr_ready, wr_last;

  always #2.5 clk = ~clk;

  pavg_accel #(.N_GROUPS(NG)) u_pavg_accel (
    .clk(clk), .rst_n(rst_n), .start(start), .in_base(in_base), .out_base(out_base),
    .done(done), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_addr(rd_addr), .rd_len(rd_len), .rd_data_valid(rd_data_valid),
    .rd_data_ready(rd_data_ready), .rd_data(rd_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_addr(wr_addr),
    .wr_len(wr_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] job_in, job_out;
  int rd_grp, wr_grp, wr_beat, rd_pend, rd_idx;
  bit wr_open, done_due;
  bit pv_rq, pv_wq, pv_wd;
  logic [31:0] pv_rq_addr, pv_wq_addr, pv_wd_data;
  logic [3:0]  pv_rq_len;
  logic        pv_wd_last;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] in_word(input int i);
    logic [31:0] u = i;
    if (i % 3 == 0) return 32'hFFFF_FF00 | {24'h0, u[7:0]};
    return u * 32'h9E37_79B1 + 32'h0000_1234;
  endfunction

  function automatic logic [31:0] exp_out(input int i);
    logic [31:0] s = in_word(i) + in_word(i + 1);
    return s >> 1;
  endfunction

  // memory slave and per-clock reference model
  initial begin
    rd_req_ready = 0; rd_data_valid = 0; rd_data = '0;
    wr_req_ready = 0; wr_ready = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        chk(!rd_req_valid && !wr_req_valid && !wr_valid && !done && !rd_data_ready,
            "R9", "outputs in reset", {27'b0, rd_req_valid, wr_req_valid, wr_valid, done, rd_data_ready}, 0);
        rd_req_ready = 0; rd_data_valid = 0; wr_req_ready = 0; wr_ready = 0;
        rd_pend = 0; wr_open = 0; done_due = 0; pv_rq = 0; pv_wq = 0; pv_wd = 0;
      end else begin
        chk(done === done_due, "R7", "done timing", {31'b0, done}, {31'b0, done_due});
        done_due = 0;
        if (pv_rq) chk(rd_req_valid && rd_addr == pv_rq_addr && rd_len == pv_rq_len,
                       "R5", "read req hold", rd_addr, pv_rq_addr);
        if (pv_wq) chk(wr_req_valid && wr_addr == pv_wq_addr, "R6", "write req hold", wr_addr, pv_wq_addr);
        if (pv_wd) chk(wr_valid && wr_data == pv_wd_data && wr_last == pv_wd_last,
                       "R6", "write beat hold", wr_data, pv_wd_data);
        rd_req_ready = ($urandom % 2) == 0;
        wr_req_ready = ($urandom % 2) == 0;
        wr_ready     = ($urandom % 3) != 0;
        if (rd_pend > 0) begin
          rd_data_valid = ($urandom % 2) == 0;
          rd_data = in_word(rd_idx);
        end else begin
          rd_data_valid = 0;
        end
        if (rd_req_valid && rd_req_ready) begin
          chk(rd_grp < NG, "R4", "read group in range", rd_grp, NG - 1);
          chk(rd_pend == 0 && !wr_open, "R3", "read req while busy", rd_pend, 0);
          chk(rd_addr == job_in + 32'(rd_grp * 16), "R2", "read address", rd_addr, job_in + 32'(rd_grp * 16));
          chk(rd_len == 4'd4, "R2", "read length", {28'b0, rd_len}, 4);
          rd_idx = rd_grp * 4; rd_pend = 5; rd_grp++;
        end
        if (rd_data_valid && rd_data_ready) begin
          rd_idx++; rd_pend--;
        end
        if (wr_req_valid && wr_req_ready) begin
          chk(rd_pend == 0 && !wr_open, "R3", "reads done before write", rd_pend, 0);
          chk(wr_grp == rd_grp - 1, "R3", "write group follows read", wr_grp, rd_grp - 1);
          chk(wr_addr == job_out + 32'(wr_grp * 16), "R3", "write address", wr_addr, job_out + 32'(wr_grp * 16));
          chk(wr_len == 4'd3, "R3", "write length", {28'b0, wr_len}, 3);
          wr_open = 1; wr_beat = 0;
        end
        if (wr_valid && wr_ready) begin
          chk(wr_open, "R3", "beat without request", 0, 1);
          chk(wr_data == exp_out(wr_grp * 4 + wr_beat), "R1", "average", wr_data, exp_out(wr_grp * 4 + wr_beat));
          chk(wr_last == (wr_beat == 3), "R3", "wr_last", {31'b0, wr_last}, {31'b0, wr_beat == 3});
          wr_beat++;
          if (wr_beat == 4) begin
            wr_open = 0; wr_grp++;
            if (wr_grp == NG) done_due = 1;
          end
        end
        pv_rq = rd_req_valid && !rd_req_ready; pv_rq_addr = rd_addr; pv_rq_len = rd_len;
        pv_wq = wr_req_valid && !wr_req_ready; pv_wq_addr = wr_addr;
        pv_wd = wr_valid && !wr_ready; pv_wd_data = wr_data; pv_wd_last = wr_last;
      end
    end
  end

  task automatic launch(input logic [31:0] ib, input logic [31:0] ob);
    job_in = ib; job_out = ob; rd_grp = 0; wr_grp = 0;
    @(negedge clk);
    in_base = ib; out_base = ob; start = 1;
    @(negedge clk);
    start = 0; in_base = 32'hDEAD_0000; out_base = 32'hBEEF_0000;
  endtask

  task automatic finish_run(input string tag);
    wait (wr_grp == NG);
    repeat (4) @(negedge clk);
    chk(rd_grp == NG, "R4", {"group count ", tag}, rd_grp, NG);
    chk(!rd_req_valid && !wr_req_valid && !wr_valid && !done, "R7", {"idle after ", tag},
        {28'b0, rd_req_valid, wr_req_valid, wr_valid, done}, 0);
  endtask

  initial begin
    rst_n = 0; start = 0; in_base = '0; out_base = '0;
    job_in = '0; job_out = '0; rd_grp = 0; wr_grp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!rd_req_valid && !done, "R9", "idle before start", {31'b0, rd_req_valid}, 0);

    // pass 1, with stray start pulses during the run (R8)
    launch(32'h0001_0000, 32'h0008_0000);
    repeat (40) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    repeat (900) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    finish_run("pass1");

    // reset in the middle of a pass (R9)
    launch(32'h0002_0000, 32'h0009_0000);
    repeat (70) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(!rd_req_valid && !wr_req_valid && !wr_valid && !done, "R9", "no request after reset",
        {28'b0, rd_req_valid, wr_req_valid, wr_valid, done}, 0);

    // pass 2 with different bases (R8 recapture)
    launch(32'h1000_0400, 32'h2000_0100);
    finish_run("pass2");

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", wr_grp, NG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule